// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the digital core of a synchronous buck power stage. It turns a pulse-width command from a controller into enables for the high-side and low-side gates. The mode-select pin chooses between two behaviours. In synchronous mode a single command drives both gates in turn, with a break-before-make handoff. In independent mode the command drives only the high-side gate and the low-enable pin drives the low-side gate directly. In synchronous mode the low-enable pin also acts as a low-side disable, which is useful when starting into a pre-charged output or when running at light load.

The controller can float its command pin. A window comparator outside the block flags a mid-rail level on that pin. When the flag persists past a hold-off window, the block parks both gates off, whatever the mode. The block leaves this parked state only when the command is seen at a valid low level, so the first phase after recovery is always low-side. The block starts parked in the same way after reset. An external fault request cuts the running cycle short on the next clock edge. It also sets a sticky fault flag that stays set until it is cleared on purpose.

Top module: `hb_gate_seq`

## Requirements
- R1: In synchronous mode (mode pin high), a high command gives high-side on and low-side off. A low command gives low-side on and high-side off.
- R2: In synchronous mode, a gate turns on only when the opposite gate's enable is off and that gate's off-feedback is asserted.
- R3: In synchronous mode, every handoff leaves both gates off for at least DEADTIME_CYC clock cycles.
- R4: In independent mode (mode pin low), the high-side gate follows the command and the low-side gate follows the low-enable pin, with no dead time, so both may be on together.
- R5: In synchronous mode, a low level on the low-enable pin keeps the low-side gate off.
- R6: A mid-level flag asserted for HOLDOFF_CYC consecutive synchronised cycles parks both gates off in any mode. A shorter excursion has no effect on the gates.
- R7: The parked state, which is also the state after reset, is left only once the mid-level flag is low and the command is low. A high command alone does not release it.
- R8: A fault request forces both gates off and sets the fault output on the next clock edge.
- R9: The fault output stays set until the clear input is high while the fault request is low.
- R10: During reset both gates are off and the fault output is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Pulse-width command (asynchronous) |
| sync_mode_i | input | 1 | 1 = synchronous mode, 0 = independent mode (asynchronous) |
| lo_en_i | input | 1 | Low-side enable or disable (asynchronous) |
| mid_lvl_i | input | 1 | Command pin sits at mid-rail (asynchronous) |
| hs_off_fb_i | input | 1 | High-side gate confirmed off |
| ls_off_fb_i | input | 1 | Low-side gate confirmed off |
| fault_req_i | input | 1 | Fault request |
| fault_clr_i | input | 1 | Synchronous fault clear |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Sticky fault flag |

## Verification
The hardest cases to reach are a gate waiting on stale feedback and a mid-level excursion that ends one cycle short of the hold-off. The bench models the gate feedback as a one-cycle-delayed inverse of each enable. A separate override holds either feedback low, which stalls a handoff indefinitely. Mid-level pulses are timed in exact cycle counts on both sides of HOLDOFF_CYC. The mode and enable pins are then flipped while the block is parked, to show that the park overrides them.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  // synchroniser bit order
  localparam int unsigned SB_PWM  = 0;
  localparam int unsigned SB_MODE = 1;
  localparam int unsigned SB_LOEN = 2;
  localparam int unsigned SB_MID  = 3;
  localparam int unsigned SB_W    = 4;
  // pwm resets high so the block cannot leave park before real input arrives
  localparam logic [SB_W-1:0] SB_RST = 4'b0001;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;
endpackage

// File: rtl/hb_sync_bank.sv
module hb_sync_bank #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_holdoff_det.sv
module hb_holdoff_det #(
  parameter int unsigned HOLDOFF_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mid_s_i,
  input  logic pwm_s_i,
  output logic park_o
);
  localparam int unsigned CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          hit;
  logic          park_q;

  assign hit = mid_s_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt_q <= '0;
    else if (!mid_s_i)    cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;

  // reset starts parked; release needs a valid low command
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    park_q <= 1'b1;
    else if (hit)                   park_q <= 1'b1;
    else if (!mid_s_i && !pwm_s_i)  park_q <= 1'b0;

  assign park_o = park_q;
endmodule

// File: rtl/hb_dead_cnt.sv
module hb_dead_cnt #(
  parameter int unsigned DEADTIME_CYC = 4  // minimum 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DEADTIME_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(DEADTIME_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (!idle_i)       cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;

  assign done_o = (cnt_q == FULL);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned HOLDOFF_CYC  = 16,
  parameter int unsigned DEADTIME_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic sync_mode_i,
  input  logic lo_en_i,
  input  logic mid_lvl_i,
  input  logic hs_off_fb_i,
  input  logic ls_off_fb_i,
  input  logic fault_req_i,
  input  logic fault_clr_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic fault_o
);
  logic [SB_W-1:0] raw, syn;
  logic pwm_s, mode_s, lo_en_s, mid_s;
  logic park_q, dt_done, idle, kill, fault_q;
  gate_pair_t gate_q, gate_d;

  assign raw[SB_PWM]  = pwm_i;
  assign raw[SB_MODE] = sync_mode_i;
  assign raw[SB_LOEN] = lo_en_i;
  assign raw[SB_MID]  = mid_lvl_i;

  hb_sync_bank #(.WIDTH(SB_W), .STAGES(SYNC_STAGES), .RST_VAL(SB_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign pwm_s   = syn[SB_PWM];
  assign mode_s  = syn[SB_MODE];
  assign lo_en_s = syn[SB_LOEN];
  assign mid_s   = syn[SB_MID];

  hb_holdoff_det #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .mid_s_i(mid_s), .pwm_s_i(pwm_s), .park_o(park_q)
  );

  assign idle = !gate_q.hs && !gate_q.ls && hs_off_fb_i && ls_off_fb_i;

  hb_dead_cnt #(.DEADTIME_CYC(DEADTIME_CYC)) u_dead (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle), .done_o(dt_done)
  );

  // fault request bypasses the synchronisers to cut the cycle at once
  assign kill = fault_req_i || fault_q || park_q;

  always_comb begin
    gate_d = '0;
    if (!kill) begin
      if (!mode_s) begin
        gate_d.hs = pwm_s;
        gate_d.ls = lo_en_s;
      end else begin
        // turn-off immediate, turn-on waits for opposite gate and dead time
        gate_d.hs = pwm_s &&
                    (gate_q.hs || (dt_done && !gate_q.ls && ls_off_fb_i));
        gate_d.ls = !pwm_s && lo_en_s &&
                    (gate_q.ls || (dt_done && !gate_q.hs && hs_off_fb_i));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          fault_q <= 1'b0;
    else if (fault_req_i) fault_q <= 1'b1;
    else if (fault_clr_i) fault_q <= 1'b0;

  assign hs_gate_o = gate_q.hs;
  assign ls_gate_o = gate_q.ls;
  assign fault_o   = fault_q;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_s_i,
  input logic park_i,
  input logic hs_off_fb_i,
  input logic ls_off_fb_i,
  input logic fault_req_i,
  input logic fault_clr_i,
  input logic hs_gate_o,
  input logic ls_gate_o,
  input logic fault_o
);
  a_r2_hs_needs_ls_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_gate_o) && $past(mode_s_i)) |-> ($past(ls_off_fb_i) && !$past(ls_gate_o)));

  a_r2_ls_needs_hs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ls_gate_o) && $past(mode_s_i)) |-> ($past(hs_off_fb_i) && !$past(hs_gate_o)));

  a_r6_park_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_i |=> (!hs_gate_o && !ls_gate_o));

  a_r8_fault_cuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i |=> (!hs_gate_o && !ls_gate_o && fault_o));

  a_r9_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

  a_r10_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (!hs_gate_o && !ls_gate_o && !fault_o));
endmodule

bind hb_gate_seq hb_gate_seq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_s_i(mode_s), .park_i(park_q),
  .hs_off_fb_i(hs_off_fb_i), .ls_off_fb_i(ls_off_fb_i),
  .fault_req_i(fault_req_i), .fault_clr_i(fault_clr_i),
  .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o), .fault_o(fault_o)
);

// File: tb/hb_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hb_gate_seq_tb_top;
  localparam int unsigned HOLD = 16;
  localparam int unsigned DEAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b1, mode = 1'b1, lo_en = 1'b1, mid = 1'b0;
  logic flt_req = 1'b0, flt_clr = 1'b0;
  logic hs_fb_q = 1'b1, ls_fb_q = 1'b1;
  logic hs_fb_blk = 1'b0, ls_fb_blk = 1'b0;
  logic hs, ls, flt;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    logic  hs;
    logic  ls;
    logic  flt;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  // gate feedback model: one cycle behind the enables
  always_ff @(posedge clk) begin
    hs_fb_q <= !hs;
    ls_fb_q <= !ls;
  end

  hb_gate_seq #(.HOLDOFF_CYC(HOLD), .DEADTIME_CYC(DEAD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .sync_mode_i(mode), .lo_en_i(lo_en),
    .mid_lvl_i(mid), .hs_off_fb_i(hs_fb_q && !hs_fb_blk), .ls_off_fb_i(ls_fb_q && !ls_fb_blk),
    .fault_req_i(flt_req), .fault_clr_i(flt_clr),
    .hs_gate_o(hs), .ls_gate_o(ls), .fault_o(flt)
  );

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (hs !== e.hs || ls !== e.ls || flt !== e.flt) begin
        n_bad++;
        $display("FAIL %s: hs/ls/flt act=%b%b%b exp=%b%b%b", e.tag, hs, ls, flt, e.hs, e.ls, e.flt);
      end
    end
  end

  task automatic expect_st(input string tag, input logic h, input logic l, input logic f);
    exp_t e;
    e.tag = tag; e.hs = h; e.ls = l; e.flt = f;
    exp_q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_int(input string tag, input bit ok, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  initial begin
    wait_n(3);
    expect_st("R10 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_n(10);
    expect_st("R7 parked after reset with pwm high", 1'b0, 1'b0, 1'b0);
    pwm = 1'b0; wait_n(14);
    expect_st("R1 pwm low ls on", 1'b0, 1'b1, 1'b0);
    pwm = 1'b1; wait_n(14);
    expect_st("R1 pwm high hs on", 1'b1, 1'b0, 1'b0);

    // R3 dead-time gap, hs off -> ls on
    pwm = 1'b0;
    begin
      int gap = 0;
      int guard = 0;
      while (hs && guard < 50) begin @(negedge clk); guard++; end
      while (!ls && guard < 50) begin @(negedge clk); gap++; guard++; end
      check_int("R3 dead time hs->ls", gap >= DEAD && ls, gap, DEAD);
    end

    lo_en = 1'b0; wait_n(8);
    expect_st("R5 low-side disabled", 1'b0, 1'b0, 1'b0);
    lo_en = 1'b1; wait_n(14);
    expect_st("R5 low-side re-enabled", 1'b0, 1'b1, 1'b0);

    // R2 blocked ls feedback stalls hs turn-on
    ls_fb_blk = 1'b1; pwm = 1'b1; wait_n(25);
    expect_st("R2 hs waits for ls off feedback", 1'b0, 1'b0, 1'b0);
    ls_fb_blk = 1'b0; wait_n(14);
    expect_st("R2 hs on after feedback", 1'b1, 1'b0, 1'b0);

    // R4 independent
    mode = 1'b0; lo_en = 1'b1; wait_n(8);
    expect_st("R4 independent both on", 1'b1, 1'b1, 1'b0);
    pwm = 1'b0; lo_en = 1'b0; wait_n(8);
    expect_st("R4 independent both off", 1'b0, 1'b0, 1'b0);
    lo_en = 1'b1; wait_n(8);
    expect_st("R4 independent ls only", 1'b0, 1'b1, 1'b0);
    mode = 1'b1; pwm = 1'b1; wait_n(16);
    expect_st("R1 back in sync hs on", 1'b1, 1'b0, 1'b0);

    // R6 short excursion ignored
    mid = 1'b1; wait_n(HOLD - 2); mid = 1'b0; wait_n(8);
    expect_st("R6 short mid excursion ignored", 1'b1, 1'b0, 1'b0);
    mid = 1'b1; wait_n(HOLD + 6);
    expect_st("R6 long mid parks", 1'b0, 1'b0, 1'b0);
    mode = 1'b0; lo_en = 1'b1; wait_n(8);
    expect_st("R6 park overrides independent", 1'b0, 1'b0, 1'b0);
    mode = 1'b1; wait_n(4);
    mid = 1'b0; wait_n(12);
    expect_st("R7 pwm high does not release", 1'b0, 1'b0, 1'b0);
    pwm = 1'b0; wait_n(14);
    expect_st("R7 release low side first", 1'b0, 1'b1, 1'b0);
    pwm = 1'b1; wait_n(14);
    expect_st("R7 hs after release", 1'b1, 1'b0, 1'b0);

    // R8 / R9 fault
    flt_req = 1'b1; @(negedge clk); flt_req = 1'b0;
    expect_st("R8 fault cuts cycle", 1'b0, 1'b0, 1'b1);
    wait_n(8);
    expect_st("R9 fault latched", 1'b0, 1'b0, 1'b1);
    flt_req = 1'b1; flt_clr = 1'b1; wait_n(3);
    flt_req = 1'b0; flt_clr = 1'b0; wait_n(2);
    expect_st("R9 clear ignored while request high", 1'b0, 1'b0, 1'b1);
    flt_clr = 1'b1; @(negedge clk); flt_clr = 1'b0; wait_n(16);
    expect_st("R9 cleared, hs resumes", 1'b1, 1'b0, 1'b0);

    while (exp_q.size() > 0) @(negedge clk);
    wait_n(2);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule